// File: doc/BRIEF.md
# Packet Address Decoder with Parity Check

This block sits on the receive side of an on-chip packet router. Packets arrive one byte per cycle on a single input that carries a valid strobe and a start-of-packet marker. The first byte of each packet is the destination address and the second is the length byte. After these come 1 to 63 payload bytes and then one check byte. The block follows each packet through these phases. It compares the destination byte with eight programmable port addresses and forwards every byte of the packet to the port that matches, raising that port's valid bit for the byte.

While the bytes arrive, the block builds an XOR parity over the header and the payload. When the check byte comes in, it reports completion and reports whether the parity disagrees. A packet whose address matches no port is still read through to its end, and a drop pulse is raised. A length of zero is treated as malformed. Output buffering, arbitration and flow control belong to the blocks around this one.

Top module: `pkt_steer`

## Requirements
- R1: While `rstN` is low at a rising edge, the next cycle shows `outValid`=0, `outData`=0 and `pktDone`, `parityErr`, `pktDrop`, `lenErr` all 0, whatever the inputs are. Reset is synchronous.
- R2: In idle, a byte with `inValid`=1 and `inSop`=1 is the destination address. Port i is selected when `portAddr[8i+7:8i]` equals that byte. Each accepted byte appears on `outData` in the cycle after the edge that took it, with only the selected port's bit set in `outValid`.
- R3: The selected port's valid bit is set for every byte from the address byte through the check byte, which is length+3 cycles in total when there are no gaps.
- R4: The payload count is bits [5:0] of the second byte, from 1 to 63. Bits [7:6] do not change the count, but they are still forwarded and still enter the parity.
- R5: The check byte is compared with the XOR of the address byte, the full length byte and every payload byte. `pktDone` pulses for one cycle together with the check byte's output cycle. `parityErr` pulses in that same cycle only if the two values differ.
- R6: If no port address matches, no `outValid` bit is set for any byte of that packet. `pktDrop` pulses in the address byte's output cycle, and the rest of the packet is consumed. `pktDone` and `parityErr` still report at its end.
- R7: A length byte whose count is 0 raises `lenErr` in that byte's output cycle and ends the packet with no `pktDone`. The next byte is treated as idle input.
- R8: In idle, a byte with `inValid`=1 and `inSop`=0 is discarded. No `outValid` bit is set for it.
- R9: After the address byte, `inSop` has no effect. A byte that carries it is forwarded as an ordinary byte of the current packet.
- R10: When several ports hold the address, only the lowest-numbered of them is selected.
- R11: A cycle with `inValid`=0 inside a packet forwards nothing in the following cycle and does not advance the packet.
- R12: A new address byte with `inSop` in the cycle right after a check byte is accepted as a new packet, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input byte is present |
| inSop | input | 1 | Input byte starts a packet (used only in idle) |
| inData | input | 8 | Input byte |
| portAddr | input | 64 | Eight port addresses; port i is bits [8i+7:8i] |
| outData | output | 8 | Forwarded byte, registered |
| outValid | output | 8 | One-hot per-port valid for `outData` |
| pktDone | output | 1 | Pulse: check byte of a packet has been taken |
| parityErr | output | 1 | Pulse: check byte disagrees with the computed parity |
| pktDrop | output | 1 | Pulse: address matched no port |
| lenErr | output | 1 | Pulse: length count was zero |

## Verification
The main same-cycle case is two port comparators firing on one address byte. The bench provokes it by reprogramming ports 3 and 5 to one shared value, and ports 1 and 6 to another, between packets. It judges the result against its own lowest-index search over the port table. A second case is the check-byte comparison on one edge followed by the parity reload for the next packet's address byte on the very next edge. Back-to-back packets with deliberately corrupted check bytes exercise this, and each byte's flags are compared with the bench's own XOR.

// File: rtl/pkt_steer_pkg.sv
`timescale 1ns/1ps
package pkt_steer_pkg;

  typedef enum logic [1:0] {
    stIdle  = 2'd0,
    stLen   = 2'd1,
    stBody  = 2'd2,
    stCheck = 2'd3
  } stateT;

  // strobes from control to datapath, valid for the current input byte
  typedef struct packed {
    logic latchAddr;  // address byte accepted
    logic fwd;        // byte belongs to a packet and is forwarded
    logic checkNow;   // check byte accepted
    logic lenBad;     // zero length count accepted
  } strobeT;

endpackage

// File: rtl/pkt_steer_ctrl.sv
`timescale 1ns/1ps
module pkt_steer_ctrl
  import pkt_steer_pkg::*;
#(
  parameter int LENW = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inSop,
  input  logic [LENW-1:0] lenField,
  output strobeT          stb
);

  localparam logic [LENW-1:0] CNT_ONE = LENW'(1);

  stateT           stateQ, stateNxt;
  logic [LENW-1:0] cntQ, cntNxt;

  always_comb begin
    stb      = '0;
    stateNxt = stateQ;
    cntNxt   = cntQ;
    stb.fwd  = inValid && ((stateQ != stIdle) || inSop);
    case (stateQ)
      stIdle: begin
        if (inValid && inSop) begin
          stb.latchAddr = 1'b1;
          stateNxt      = stLen;
        end
      end
      stLen: begin
        if (inValid) begin
          if (lenField == '0) begin
            stb.lenBad = 1'b1;
            stateNxt   = stIdle;
          end else begin
            cntNxt   = lenField;
            stateNxt = stBody;
          end
        end
      end
      stBody: begin
        if (inValid) begin
          cntNxt = cntQ - CNT_ONE;
          if (cntQ == CNT_ONE) stateNxt = stCheck;
        end
      end
      stCheck: begin
        if (inValid) begin
          stb.checkNow = 1'b1;
          stateNxt     = stIdle;
        end
      end
      default: stateNxt = stIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= stIdle;
      cntQ   <= '0;
    end else begin
      stateQ <= stateNxt;
      cntQ   <= cntNxt;
    end
  end

endmodule

// File: rtl/pkt_steer_dpath.sv
`timescale 1ns/1ps
module pkt_steer_dpath
  import pkt_steer_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stb,
  input  logic [DW-1:0]       inData,
  input  logic [NPORT*DW-1:0] portAddr,
  output logic [DW-1:0]       outData,
  output logic [NPORT-1:0]    outValid,
  output logic                pktDone,
  output logic                parityErr,
  output logic                pktDrop,
  output logic                lenErr
);

  logic [NPORT-1:0] hit;
  logic [NPORT-1:0] pick;
  logic             found;
  logic [NPORT-1:0] selQ;
  logic [DW-1:0]    parQ;

  // one comparator per port
  for (genvar g = 0; g < NPORT; g++) begin : gCmp
    assign hit[g] = (portAddr[g*DW +: DW] == inData);
  end

  // lowest index wins when addresses repeat
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (hit[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ      <= '0;
      parQ      <= '0;
      outData   <= '0;
      outValid  <= '0;
      pktDone   <= 1'b0;
      parityErr <= 1'b0;
      pktDrop   <= 1'b0;
      lenErr    <= 1'b0;
    end else begin
      if (stb.latchAddr) selQ <= pick;
      if (stb.latchAddr)      parQ <= inData;
      else if (stb.fwd)       parQ <= parQ ^ inData;
      if (stb.fwd) outData <= inData;
      if (!stb.fwd)           outValid <= '0;
      else if (stb.latchAddr) outValid <= pick;
      else                    outValid <= selQ;
      pktDone   <= stb.checkNow;
      parityErr <= stb.checkNow && (parQ != inData);
      pktDrop   <= stb.latchAddr && !found;
      lenErr    <= stb.lenBad;
    end
  end

endmodule

// File: rtl/pkt_steer.sv
`timescale 1ns/1ps
module pkt_steer
  import pkt_steer_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int DW    = 8,
  parameter int LENW  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inSop,
  input  logic [DW-1:0]       inData,
  input  logic [NPORT*DW-1:0] portAddr,
  output logic [DW-1:0]       outData,
  output logic [NPORT-1:0]    outValid,
  output logic                pktDone,
  output logic                parityErr,
  output logic                pktDrop,
  output logic                lenErr
);

  strobeT stb;

  pkt_steer_ctrl #(.LENW(LENW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSop    (inSop),
    .lenField (inData[LENW-1:0]),
    .stb      (stb)
  );

  pkt_steer_dpath #(.NPORT(NPORT), .DW(DW)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .inData    (inData),
    .portAddr  (portAddr),
    .outData   (outData),
    .outValid  (outValid),
    .pktDone   (pktDone),
    .parityErr (parityErr),
    .pktDrop   (pktDrop),
    .lenErr    (lenErr)
  );

endmodule

// File: rtl/pkt_steer_chk.sv
`timescale 1ns/1ps
module pkt_steer_chk #(
  parameter int NPORT = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [NPORT-1:0] outValid,
  input logic             pktDone,
  input logic             parityErr,
  input logic             pktDrop,
  input logic             lenErr
);

  // R2
  onehot_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outValid));

  // R6
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktDrop |-> (outValid == '0));

  // R5
  err_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> pktDone);

  // R7
  lenerr_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> (!pktDone && !parityErr));

  // R11
  stall_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ((outValid == '0) && !pktDone));

endmodule

bind pkt_steer pkt_steer_chk #(.NPORT(NPORT)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .outValid  (outValid),
  .pktDone   (pktDone),
  .parityErr (parityErr),
  .pktDrop   (pktDrop),
  .lenErr    (lenErr)
);

// File: tb/sim_pkt_steer.sv
`timescale 1ns/1ps
module sim_pkt_steer;

  localparam int NP = 8;

  logic            clk = 1'b0;
  logic            rstN;
  logic            inValid;
  logic            inSop;
  logic [7:0]      inData;
  logic [7:0]      cfg [NP];
  logic [NP*8-1:0] portAddr;
  logic [7:0]      outData;
  logic [NP-1:0]   outValid;
  logic            pktDone, parityErr, pktDrop, lenErr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) portAddr[i*8 +: 8] = cfg[i];
  end

  pkt_steer u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inData(inData),
    .portAddr(portAddr), .outData(outData), .outValid(outValid),
    .pktDone(pktDone), .parityErr(parityErr), .pktDrop(pktDrop), .lenErr(lenErr)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // drive one byte, then sample the registered result just after the edge
  task automatic step(input logic v, input logic s, input logic [7:0] d,
                      input logic [7:0] eV, input logic [7:0] eD,
                      input logic eDone, input logic eErr,
                      input logic eDrop, input logic eLen, input string tag);
    @(negedge clk);
    inValid = v; inSop = s; inData = d;
    @(posedge clk);
    #1;
    chk(tag, "outValid", outValid, eV);
    if (eV != '0) chk(tag, "outData", outData, eD);
    chk("R5", "pktDone", {7'b0, pktDone}, {7'b0, eDone});
    chk("R5", "parityErr", {7'b0, parityErr}, {7'b0, eErr});
    chk("R6", "pktDrop", {7'b0, pktDrop}, {7'b0, eDrop});
    chk("R7", "lenErr", {7'b0, lenErr}, {7'b0, eLen});
  endtask

  task automatic sendPkt(input logic [7:0] addr, input logic [7:0] lenB,
                         input logic [7:0] seed, input bit bad,
                         input bit sopMid, input int gap, input string tag);
    logic [7:0] eV;
    logic [7:0] par;
    logic [7:0] b;
    int n;
    bit drop;
    eV = '0;
    for (int i = 0; i < NP; i++)
      if (cfg[i] == addr && eV == '0) eV = 8'(1 << i);
    drop = (eV == '0);
    n = int'(lenB[5:0]);
    step(1'b1, 1'b1, addr, eV, addr, 1'b0, 1'b0, drop, 1'b0, tag);
    if (n == 0) begin
      step(1'b1, 1'b0, lenB, eV, lenB, 1'b0, 1'b0, 1'b0, 1'b1, tag);
      return;
    end
    step(1'b1, 1'b0, lenB, eV, lenB, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    par = addr ^ lenB;
    for (int i = 0; i < n; i++) begin
      b = seed + 8'(i * 7);
      par ^= b;
      step(1'b1, sopMid && (i == 0), b, eV, b, 1'b0, 1'b0, 1'b0, 1'b0, tag);
      if (gap > 0 && (i % gap) == gap - 1)
        step(1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    end
    b = bad ? (par ^ 8'h80) : par;
    step(1'b1, 1'b0, b, eV, b, 1'b1, bad, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int lens [4];
    lens[0] = 1; lens[1] = 2; lens[2] = 5; lens[3] = 63;
    for (int i = 0; i < NP; i++) cfg[i] = 8'h11 + 8'(i * 8'h1D);
    rstN = 1'b0; inValid = 1'b0; inSop = 1'b0; inData = 8'h00;

    // R1: reset holds outputs low even with a start byte present
    for (int k = 0; k < 3; k++)
      step(1'b1, 1'b1, cfg[0], 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    chk("R1", "outData", outData, 8'h00);
    @(negedge clk);
    rstN = 1'b1; inValid = 1'b0; inSop = 1'b0;

    // R3/R4/R5: every port, several lengths, good and bad check bytes
    for (int p = 0; p < NP; p++)
      for (int li = 0; li < 4; li++)
        for (int bd = 0; bd < 2; bd++)
          sendPkt(cfg[p], {2'(li), 6'(lens[li])}, 8'(p * 16 + li), bit'(bd),
                  1'b0, 0, (li != 0) ? "R4" : "R3");

    // R2/R6: sweep of all address values
    for (int a = 0; a < 256; a++)
      sendPkt(8'(a), 8'h01, 8'(a), 1'b0, 1'b0, 0, "R2");

    // R7: zero length, then R8 stray bytes in idle
    sendPkt(cfg[2], 8'hC0, 8'h00, 1'b0, 1'b0, 0, "R7");
    step(1'b1, 1'b0, 8'h55, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, cfg[4], 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    sendPkt(cfg[4], 8'h03, 8'h21, 1'b0, 1'b0, 0, "R8");

    // R9: start marker on a payload byte
    sendPkt(cfg[1], 8'h04, cfg[5], 1'b1, 1'b1, 0, "R9");

    // R11: gaps inside the payload
    sendPkt(cfg[7], 8'h06, 8'h3C, 1'b0, 1'b0, 2, "R11");
    sendPkt(cfg[6], 8'h05, 8'h90, 1'b1, 1'b0, 1, "R11");

    // R10: duplicated port addresses
    cfg[3] = 8'hC3; cfg[5] = 8'hC3; cfg[6] = cfg[1];
    sendPkt(8'hC3, 8'h02, 8'h07, 1'b0, 1'b0, 0, "R10");
    sendPkt(cfg[1], 8'h03, 8'h70, 1'b1, 1'b0, 0, "R10");

    // R12: back-to-back packets, no idle cycle between them
    sendPkt(cfg[0], 8'h01, 8'hA5, 1'b1, 1'b0, 0, "R12");
    sendPkt(cfg[7], 8'h01, 8'h5A, 1'b0, 1'b0, 0, "R12");
    sendPkt(8'h00, 8'h02, 8'h01, 1'b1, 1'b0, 0, "R12");

    step(1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule